// File: doc/BRIEF.md
# Lane Comma-Run Synchronization Receiver

This block runs the code group synchronization phase of one receive lane of a converter serial link. It sits after the 8b/10b decoder. Each clock it may accept one decoded character, marked valid by a strobe. Each character comes with an 8-bit value, a control flag and a decode/disparity error flag. While the lane is unsynchronized, the block drives its active-low sync request low. It counts clean comma characters that arrive back to back. Once the run is long enough, it releases the request and raises a completion flag, which starts the initial lane alignment phase downstream.

The block has two named states. In `ST_HUNT` the sync request is low and the run counter is live. In `ST_LOCKED` the sync request is high, the completion flag is high and an error-window monitor is live. There are three transitions. *Acquire* goes from `ST_HUNT` to `ST_LOCKED` on the accepted character that completes the comma run. *Error-drop* goes from `ST_LOCKED` to `ST_HUNT` when too many decode errors land inside one window of accepted characters. *Resync* goes from either state to `ST_HUNT` on a synchronous reset or an external resync request. The run counter and the error monitor are cleared whenever their state is not the live one. Both outputs are registered and change on the same edge as the state.

Top module: `cgs_rx_sync`

## Requirements
- R1: After synchronous reset, `sync_n` is 0 and `cgs_done` is 0.
- R2: A clean comma is an accepted character with value 0xBC, `char_is_ctrl`=1 and `char_err`=0. On the clock edge that accepts the COMMA_RUN-th (default 4) consecutive clean comma in `ST_HUNT`, `sync_n` and `cgs_done` both go to 1.
- R3: Fewer than COMMA_RUN consecutive clean commas leave `sync_n` at 0 and `cgs_done` at 0.
- R4: In `ST_HUNT`, an accepted character that is not a comma resets the run to zero, so COMMA_RUN new commas are needed. This covers a control character other than 0xBC, and 0xBC with `char_is_ctrl`=0.
- R5: In `ST_HUNT`, an accepted 0xBC control character with `char_err`=1 resets the run to zero.
- R6: Cycles with `char_valid`=0 neither advance nor break the run, whatever the other character inputs hold.
- R7: A cycle with `resync_req`=1 moves the block to `ST_HUNT` from either state. One edge later `sync_n`=0 and `cgs_done`=0, and the run restarts from zero.
- R8: In `ST_LOCKED`, the accepted character that brings the error count to ERR_LIMIT (default 3) within one window returns the block to `ST_HUNT` on that edge. A window is ERR_WINDOW (default 16) accepted characters, counted from the first accepted character after lock.
- R9: The error count clears at each window boundary, so fewer than ERR_LIMIT errors per window keep the lock.
- R10: In `ST_LOCKED`, error-free data characters of any value, including non-commas, leave `sync_n` and `cgs_done` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous reset, active high |
| resync_req | input | 1 | Request to restart synchronization |
| char_valid | input | 1 | A character is presented this cycle |
| char_data | input | 8 | Decoded character value |
| char_is_ctrl | input | 1 | Character is a control character |
| char_err | input | 1 | Decode or disparity error on this character |
| sync_n | output | 1 | Active-low synchronization request |
| cgs_done | output | 1 | Comma synchronization complete; alignment phase may start |

## Verification
A run counter stuck, off by one, or not cleared by errors, non-commas or resync shows up at `sync_n`. The release arrives one character early or late, or after a broken run, on the edge after the deciding character. A faulty error window shows up as a lock that survives a burst of errors, or that drops on spread-out errors. This is visible on the edge that accepts the ERR_LIMIT-th error, or on the first error after a window boundary. Idle cycles carrying comma-like data check that the valid strobe really gates both counters.

// File: rtl/cgs_rx_pkg.sv
package cgs_rx_pkg;

    typedef enum logic {
        ST_HUNT   = 1'b0,
        ST_LOCKED = 1'b1
    } cgs_state_e;

    localparam logic [7:0] COMMA_CODE = 8'hBC;

    function automatic logic is_clean_comma(input logic [7:0] data,
                                            input logic       ctrl,
                                            input logic       err);
        return ctrl && !err && (data == COMMA_CODE);
    endfunction

endpackage

// File: rtl/comma_run_counter.sv
module comma_run_counter
    import cgs_rx_pkg::*;
#(
    parameter int COMMA_RUN = 4
) (
    input  logic       clk,
    input  logic       clr,
    input  logic       char_valid,
    input  logic [7:0] char_data,
    input  logic       char_is_ctrl,
    input  logic       char_err,
    output logic       run_met
);
    localparam int CNT_W = $clog2(COMMA_RUN + 1);
    localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(COMMA_RUN - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             good;

    assign good    = is_clean_comma(char_data, char_is_ctrl, char_err);
    assign run_met = !clr && char_valid && good && (cnt_q == RUN_LAST);

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt_q <= '0;
        end else if (char_valid) begin
            if (!good)
                cnt_q <= '0;
            else if (cnt_q != RUN_LAST)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4 R5
    run_reset_chk: assert property (@(posedge clk) disable iff (clr)
        (char_valid && !good) |=> (cnt_q == '0));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (clr)
        !char_valid |=> $stable(cnt_q));

    // R3
    run_bound_chk: assert property (@(posedge clk) disable iff (clr)
        cnt_q <= RUN_LAST);

endmodule

// File: rtl/err_window_monitor.sv
module err_window_monitor #(
    parameter int ERR_LIMIT  = 3,
    parameter int ERR_WINDOW = 16
) (
    input  logic clk,
    input  logic clr,
    input  logic char_valid,
    input  logic char_err,
    output logic fault
);
    localparam int WIN_W = (ERR_WINDOW > 1) ? $clog2(ERR_WINDOW) : 1;
    localparam int ERR_W = $clog2(ERR_LIMIT + 1);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(ERR_WINDOW - 1);
    localparam logic [ERR_W-1:0] ERR_LAST = ERR_W'(ERR_LIMIT - 1);

    logic [WIN_W-1:0] win_q;
    logic [ERR_W-1:0] errs_q;

    assign fault = !clr && char_valid && char_err && (errs_q == ERR_LAST);

    always_ff @(posedge clk) begin
        if (clr) begin
            win_q  <= '0;
            errs_q <= '0;
        end else if (char_valid) begin
            if (win_q == WIN_LAST) begin
                win_q  <= '0;
                errs_q <= '0;
            end else begin
                win_q <= win_q + 1'b1;
                if (char_err && errs_q != ERR_LAST)
                    errs_q <= errs_q + 1'b1;
            end
        end
    end

    // R8
    err_bound_chk: assert property (@(posedge clk) disable iff (clr)
        errs_q <= ERR_LAST);

    // R9
    window_clear_chk: assert property (@(posedge clk) disable iff (clr)
        (char_valid && win_q == WIN_LAST) |=> (errs_q == '0));

endmodule

// File: rtl/cgs_rx_sync.sv
module cgs_rx_sync
    import cgs_rx_pkg::*;
#(
    parameter int COMMA_RUN  = 4,
    parameter int ERR_LIMIT  = 3,
    parameter int ERR_WINDOW = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       resync_req,
    input  logic       char_valid,
    input  logic [7:0] char_data,
    input  logic       char_is_ctrl,
    input  logic       char_err,
    output logic       sync_n,
    output logic       cgs_done
);
    cgs_state_e state_q, state_d;
    logic       run_met;
    logic       fault;
    logic       run_clr;
    logic       mon_clr;

    assign run_clr = rst || resync_req || (state_q != ST_HUNT);
    assign mon_clr = rst || resync_req || (state_q != ST_LOCKED);

    comma_run_counter #(.COMMA_RUN(COMMA_RUN)) u_run (
        .clk          (clk),
        .clr          (run_clr),
        .char_valid   (char_valid),
        .char_data    (char_data),
        .char_is_ctrl (char_is_ctrl),
        .char_err     (char_err),
        .run_met      (run_met)
    );

    err_window_monitor #(.ERR_LIMIT(ERR_LIMIT), .ERR_WINDOW(ERR_WINDOW)) u_mon (
        .clk        (clk),
        .clr        (mon_clr),
        .char_valid (char_valid),
        .char_err   (char_err),
        .fault      (fault)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT:   if (run_met) state_d = ST_LOCKED;
            ST_LOCKED: if (fault)   state_d = ST_HUNT;
        endcase
        if (resync_req)
            state_d = ST_HUNT;
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_HUNT;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_n   <= 1'b0;
            cgs_done <= 1'b0;
        end else begin
            sync_n   <= (state_d == ST_LOCKED);
            cgs_done <= (state_d == ST_LOCKED);
        end
    end

    // R1
    reset_out_chk: assert property (@(posedge clk)
        rst |=> (!sync_n && !cgs_done));

    // R2
    release_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_n) |-> $past(char_valid && char_is_ctrl && !char_err
                                && char_data == COMMA_CODE));

    // R7
    resync_drop_chk: assert property (@(posedge clk) disable iff (rst)
        resync_req |=> (!sync_n && !cgs_done));

    // R10
    clean_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cgs_done && !resync_req && (!char_valid || !char_err)) |=> cgs_done);

endmodule

// File: tb/cgs_rx_sync_test.sv
`timescale 1ns/1ps
module cgs_rx_sync_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       resync_req = 1'b0;
    logic       char_valid = 1'b0;
    logic [7:0] char_data = 8'h00;
    logic       char_is_ctrl = 1'b0;
    logic       char_err = 1'b0;
    logic       sync_n;
    logic       cgs_done;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cgs_rx_sync uut (
        .clk(clk), .rst(rst), .resync_req(resync_req),
        .char_valid(char_valid), .char_data(char_data),
        .char_is_ctrl(char_is_ctrl), .char_err(char_err),
        .sync_n(sync_n), .cgs_done(cgs_done)
    );

    task automatic check_out(input logic exp_lock, input string req);
        tests++;
        if (sync_n !== exp_lock || cgs_done !== exp_lock) begin
            fails++;
            $display("FAIL %s: sync_n=%b cgs_done=%b expected %b/%b",
                     req, sync_n, cgs_done, exp_lock, exp_lock);
        end
    endtask

    task automatic send(input logic [7:0] d, input logic k, input logic e);
        char_valid = 1'b1; char_data = d; char_is_ctrl = k; char_err = e;
        @(negedge clk);
        char_valid = 1'b0;
    endtask

    task automatic commas(input int n);
        for (int i = 0; i < n; i++) send(8'hBC, 1'b1, 1'b0);
    endtask

    task automatic do_resync();
        resync_req = 1'b1;
        @(negedge clk);
        resync_req = 1'b0;
    endtask

    task automatic t_reset();
        check_out(1'b0, "R1 reset");
    endtask

    task automatic t_lock();
        commas(3);
        check_out(1'b0, "R3 three commas");
        commas(1);
        check_out(1'b1, "R2 fourth comma");
    endtask

    task automatic t_resync_locked();
        do_resync();
        check_out(1'b0, "R7 resync from locked");
    endtask

    task automatic t_non_comma();
        commas(2);
        send(8'h1C, 1'b1, 1'b0);
        commas(3);
        check_out(1'b0, "R4 other control breaks run");
        send(8'hBC, 1'b0, 1'b0);
        commas(3);
        check_out(1'b0, "R4 data 0xBC breaks run");
        commas(1);
        check_out(1'b1, "R4 relock after fresh run");
        do_resync();
    endtask

    task automatic t_err_comma();
        commas(3);
        send(8'hBC, 1'b1, 1'b1);
        commas(3);
        check_out(1'b0, "R5 errored comma breaks run");
        commas(1);
        check_out(1'b1, "R5 relock");
        do_resync();
    endtask

    task automatic t_gap();
        commas(2);
        char_data = 8'h00; char_is_ctrl = 1'b0; char_err = 1'b1;
        repeat (3) @(negedge clk);
        char_data = 8'hBC; char_is_ctrl = 1'b1; char_err = 1'b0;
        @(negedge clk);
        commas(1);
        check_out(1'b0, "R6 idle neither breaks nor counts");
        commas(1);
        check_out(1'b1, "R6 run spans idle cycles");
        do_resync();
    endtask

    task automatic t_resync_hunt();
        commas(3);
        do_resync();
        commas(1);
        check_out(1'b0, "R7 resync clears run");
        commas(3);
        check_out(1'b1, "R7 full run after resync");
    endtask

    task automatic t_data();
        for (int i = 0; i < 20; i++) send(8'(i * 37 + 5), 1'b0, 1'b0);
        check_out(1'b1, "R10 data keeps lock");
        do_resync();
        commas(4);
    endtask

    task automatic t_err_burst();
        send(8'h10, 1'b0, 1'b1);
        send(8'h11, 1'b0, 1'b1);
        check_out(1'b1, "R8 two errors keep lock");
        send(8'h12, 1'b0, 1'b1);
        check_out(1'b0, "R8 third error drops lock");
        commas(4);
        check_out(1'b1, "R8 relock");
    endtask

    task automatic t_err_spread();
        send(8'h20, 1'b0, 1'b1);
        send(8'h21, 1'b0, 1'b1);
        for (int i = 0; i < 14; i++) send(8'h30, 1'b0, 1'b0);
        send(8'h22, 1'b0, 1'b1);
        send(8'h23, 1'b0, 1'b1);
        check_out(1'b1, "R9 window boundary clears errors");
        send(8'h24, 1'b0, 1'b1);
        check_out(1'b0, "R8 third error in second window");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_lock();
        t_resync_locked();
        t_non_comma();
        t_err_comma();
        t_gap();
        t_resync_hunt();
        t_data();
        t_err_burst();
        t_err_spread();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule